// File: doc/BRIEF.md
# Quad Setting Serial Command Interface

This block is the digital front end of a four-channel, 8-bit programmable voltage source. A host shifts frames in over a three-wire serial link made of a serial clock, an active-high select and a data line. Each frame starts with a logic-1 start bit. Next come a channel address and eight data bits, each field least significant bit first. The block keeps one volatile setting per channel, and these settings drive the converter codes. A non-volatile store, modelled here as a reset-loaded register array, supplies the default for each channel.

The readback is destructive. While the new data bits shift in, the previous setting of the addressed channel shifts out on the serial data output. The new value takes effect on the clock after the last data bit. When the select goes low, every channel falls back to its stored value. A frame cut short by that drop therefore acts as a read-only poll. The serial pins are synchronised to the system clock. The serial clock's rising edge is found in the system domain.

The frame state machine has four states:
- `ST_IDLE`: waits for a start bit. A 0 on the data line keeps it there.
- `ST_ADDR`: collects the address bits. After the last one it moves to `ST_DATA` and loads the old setting for output.
- `ST_DATA`: shifts the data in and the old setting out. After the eighth bit it commits the new setting and moves to `ST_GAP`.
- `ST_GAP`: lets two serial clocks pass unused, then returns to `ST_IDLE`.

A filtered low select sends any state straight to `ST_IDLE`.

Top module: `qdac_serial_if`

## Requirements
- R1: After reset, `dac_code` equals the stored defaults, `ser_do_oe` is 0 and `ser_do` is 0.
- R2: A frame has these parts in order: a 1 start bit, the address bits A0 then A1, and the data bits D0 through D7. The channel index is {A1,A0}, and channel c occupies `dac_code[8c+7:8c]`. That channel, and only that channel, takes the new value after the D7 serial clock.
- R3: After the A1 clock, `ser_do` presents the addressed channel's previous setting. Bit i is on the line before the D(i) serial clock, starting from bit 0. Outside the data phase `ser_do` is 0.
- R4: While the block waits for a start bit, serial clocks with DI=0 are ignored.
- R5: The two serial clocks after D7 are ignored whatever DI holds. The next start bit is accepted only after them.
- R6: `ser_do_oe` is 1 while the synchronised select is high, and 0 once the select drop has been filtered.
- R7: When the select stays low for `CS_FILT` consecutive samples, all channels reload their stored values.
- R8: A select low pulse shorter than `CS_FILT` samples changes neither the settings nor the output enable.
- R9: If the select drops in the middle of a frame, the partial frame is discarded and the settings revert. The next frame after the select returns starts from a fresh start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the stored defaults |
| ser_clk | input | 1 | Serial bit clock; bits are taken on its rising edge |
| ser_cs | input | 1 | Active-high select; a filtered low reverts all settings |
| ser_di | input | 1 | Serial data in |
| ser_do | output | 1 | Serial data out: the old setting during the data phase |
| ser_do_oe | output | 1 | Output enable for the external tri-state pad driver |
| dac_code | output | NCH*W | Current settings, channel 0 in the low byte |

## Verification
The hardest situation to reach is a frame that lines up correctly only because the guard clocks were ignored. The bench puts 1 bits into both guard slots after a frame and then sends a normal frame. If a guard bit were taken as a start bit, every later field would land one place off. The second hard case is a select drop in the middle of a frame, or one shorter than the filter. Both are produced by driving the select for an exact number of system clocks. The random frames also drop the select at random points between frames.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } frame_st_e;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/qdac_cs_filter.sv
module qdac_cs_filter #(
    parameter int FILT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_sync,
    output logic cs_act
);

    localparam int CW = $clog2(FILT + 1);
    localparam logic [CW-1:0] LOW_LAST = CW'(FILT - 1);

    logic [CW-1:0] low_cnt_q;
    logic          act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
            act_q     <= 1'b0;
        end else if (cs_sync) begin
            low_cnt_q <= '0;
            act_q     <= 1'b1;
        end else if (act_q) begin
            if (low_cnt_q == LOW_LAST) begin
                low_cnt_q <= '0;
                act_q     <= 1'b0;
            end else begin
                low_cnt_q <= low_cnt_q + 1'b1;
            end
        end
    end

    assign cs_act = act_q;

endmodule

// File: rtl/qdac_frame_fsm.sv
module qdac_frame_fsm
    import qdac_pkg::*;
#(
    parameter int W   = 8,
    parameter int AW  = 2,
    parameter int GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          tick,
    input  logic          di,
    input  logic [W-1:0]  rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [W-1:0]  wr_data,
    output logic          sdo,
    output logic          idle
);

    localparam int CNT_MAX = (W > GAP) ? W : GAP;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] ADDR_LAST = CW'(AW - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(W - 1);
    localparam logic [CW-1:0] GAP_LAST  = CW'(GAP - 1);

    frame_st_e     st_q, st_nxt;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic [W-1:0]  sr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nxt;
        end
    end

    // next state
    always_comb begin
        st_nxt = st_q;
        if (!cs_act) begin
            st_nxt = ST_IDLE;
        end else if (tick) begin
            unique case (st_q)
                ST_IDLE: if (di)                  st_nxt = ST_ADDR;
                ST_ADDR: if (cnt_q == ADDR_LAST)  st_nxt = ST_DATA;
                ST_DATA: if (cnt_q == DATA_LAST)  st_nxt = ST_GAP;
                ST_GAP:  if (cnt_q == GAP_LAST)   st_nxt = ST_IDLE;
                default:                          st_nxt = ST_IDLE;
            endcase
        end
    end

    // address bits as they arrive, used for the read of the old setting
    always_comb begin
        for (int i = 0; i < AW; i++) begin
            rd_addr[i] = (st_q == ST_ADDR && cnt_q == CW'(i)) ? di : addr_q[i];
        end
    end

    // bit counter, address and the shared in/out shift register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            sr_q   <= '0;
        end else if (!cs_act) begin
            cnt_q  <= '0;
            addr_q <= '0;
            sr_q   <= '0;
        end else if (tick) begin
            unique case (st_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                end
                ST_ADDR: begin
                    addr_q <= rd_addr;
                    if (cnt_q == ADDR_LAST) begin
                        cnt_q <= '0;
                        sr_q  <= rd_data;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    sr_q  <= {di, sr_q[W-1:1]};
                    cnt_q <= (cnt_q == DATA_LAST) ? '0 : cnt_q + 1'b1;
                end
                ST_GAP: begin
                    cnt_q <= (cnt_q == GAP_LAST) ? '0 : cnt_q + 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en   = cs_act && tick && (st_q == ST_DATA) && (cnt_q == DATA_LAST);
        wr_addr = addr_q;
        wr_data = {di, sr_q[W-1:1]};
        sdo     = (st_q == ST_DATA) ? sr_q[0] : 1'b0;
        idle    = (st_q == ST_IDLE);
    end

endmodule

// File: rtl/qdac_setting_bank.sv
module qdac_setting_bank #(
    parameter int NCH = 4,
    parameter int W   = 8,
    parameter int AW  = 2,
    parameter logic [NCH*W-1:0] NV_INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_act,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [W-1:0]    wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [W-1:0]    rd_data,
    output logic [NCH*W-1:0] code_flat,
    output logic [NCH*W-1:0] nv_flat
);

    logic [W-1:0] nv_q  [NCH];
    logic [W-1:0] set_q [NCH];

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            // stored default, loaded at power-on only
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    nv_q[c] <= NV_INIT[c*W +: W];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    set_q[c] <= NV_INIT[c*W +: W];
                end else if (!cs_act) begin
                    set_q[c] <= nv_q[c];
                end else if (wr_en && wr_addr == AW'(c)) begin
                    set_q[c] <= wr_data;
                end
            end

            assign code_flat[c*W +: W] = set_q[c];
            assign nv_flat[c*W +: W]   = nv_q[c];
        end
    endgenerate

    assign rd_data = set_q[rd_addr];

endmodule

// File: rtl/qdac_serial_if.sv
module qdac_serial_if #(
    parameter int NCH         = 4,
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CS_FILT     = 4,
    parameter int GAP         = 2,
    parameter logic [NCH*W-1:0] NV_INIT = {NCH{{1'b1, {(W-1){1'b0}}}}}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_cs,
    input  logic             ser_di,
    output logic             ser_do,
    output logic             ser_do_oe,
    output logic [NCH*W-1:0] dac_code
);

    localparam int AW = $clog2(NCH);

    logic [2:0]     pins_s;
    logic           sclk_s, di_s, cs_s;
    logic           sclk_q;
    logic           sclk_rise;
    logic           cs_act;
    logic [AW-1:0]  rd_addr, wr_addr;
    logic [W-1:0]   rd_data, wr_data;
    logic           wr_en;
    logic           fsm_idle;
    logic [NCH*W-1:0] nv_flat;

    qdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_clk, ser_di, ser_cs}),
        .q     (pins_s)
    );

    assign {sclk_s, di_s, cs_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;

    qdac_cs_filter #(.FILT(CS_FILT)) u_csf (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_sync (cs_s),
        .cs_act  (cs_act)
    );

    qdac_frame_fsm #(.W(W), .AW(AW), .GAP(GAP)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_act  (cs_act),
        .tick    (sclk_rise),
        .di      (di_s),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .sdo     (ser_do),
        .idle    (fsm_idle)
    );

    qdac_setting_bank #(.NCH(NCH), .W(W), .AW(AW), .NV_INIT(NV_INIT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .code_flat (dac_code),
        .nv_flat   (nv_flat)
    );

    assign ser_do_oe = cs_act;

endmodule

// File: rtl/qdac_serial_if_chk.sv
module qdac_serial_if_chk #(
    parameter int NCH = 4,
    parameter int W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH*W-1:0] dac_code,
    input logic [NCH*W-1:0] nv_flat,
    input logic             ser_do,
    input logic             ser_do_oe,
    input logic             tick,
    input logic             fsm_idle
);

    logic [NCH*W-1:0] prev_code_q;
    logic [NCH-1:0]   chg;

    always_ff @(posedge clk) begin
        prev_code_q <= dac_code;
    end

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_chg
            assign chg[c] = dac_code[c*W +: W] != prev_code_q[c*W +: W];
        end
    endgenerate

    // R7
    revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_do_oe |=> dac_code == nv_flat);

    // R2
    one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_do_oe && $past(ser_do_oe)) |-> $countones(chg) <= 1);

    // R2
    commit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_do_oe && $past(ser_do_oe) && dac_code != $past(dac_code)) |-> $past(tick));

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> !ser_do);

endmodule

bind qdac_serial_if qdac_serial_if_chk #(.NCH(NCH), .W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dac_code  (dac_code),
    .nv_flat   (nv_flat),
    .ser_do    (ser_do),
    .ser_do_oe (ser_do_oe),
    .tick      (sclk_rise),
    .fsm_idle  (fsm_idle)
);

// File: tb/qdac_serial_if_tb.sv
module qdac_serial_if_tb;

    localparam logic [31:0] NV = 32'hC35A_8117;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_cs = 1'b0;
    logic        ser_di = 1'b0;
    logic        ser_do;
    logic        ser_do_oe;
    logic [31:0] dac_code;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] nvm [4];
    logic [7:0] cur [4];

    always #5 clk = ~clk;

    qdac_serial_if #(.NCH(4), .W(8), .SYNC_STAGES(2), .CS_FILT(4), .GAP(2), .NV_INIT(NV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_clk   (ser_clk),
        .ser_cs    (ser_cs),
        .ser_di    (ser_di),
        .ser_do    (ser_do),
        .ser_do_oe (ser_do_oe),
        .dac_code  (dac_code)
    );

    function automatic logic [31:0] exp_code();
        logic [31:0] e;
        for (int c = 0; c < 4; c++) e[c*8 +: 8] = cur[c];
        return e;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, output logic so);
        @(negedge clk);
        ser_di = b;
        repeat (4) @(negedge clk);
        so = ser_do;
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_frame(input int ch, input logic [7:0] data, output logic [7:0] old);
        logic so;
        send_bit(1'b1, so);
        send_bit(ch[0], so);
        send_bit(ch[1], so);
        for (int i = 0; i < 8; i++) begin
            send_bit(data[i], so);
            old[i] = so;
        end
        cur[ch] = data;
        repeat (3) @(negedge clk);
    endtask

    task automatic cs_up();
        @(negedge clk);
        ser_cs = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic cs_down();
        @(negedge clk);
        ser_cs = 1'b0;
        repeat (12) @(negedge clk);
        for (int c = 0; c < 4; c++) cur[c] = nvm[c];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] old;
        logic so;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 4; c++) begin
            nvm[c] = NV[c*8 +: 8];
            cur[c] = nvm[c];
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state
        chk("R1 code", dac_code, NV);
        chk("R1 oe", {31'd0, ser_do_oe}, 32'd0);
        chk("R1 do", {31'd0, ser_do}, 32'd0);

        // R6 enable follows select
        cs_up();
        chk("R6 oe high", {31'd0, ser_do_oe}, 32'd1);

        // R4 leading zeros ignored
        for (int i = 0; i < 3; i++) send_bit(1'b0, so);
        chk("R4 idle zeros no change", dac_code, exp_code());
        send_frame(2, 8'h3C, old);
        chk("R3 old ch2", {24'd0, old}, {24'd0, nvm[2]});
        chk("R2 write ch2", dac_code, exp_code());

        // R5 guard bits set to 1 are not start bits
        send_bit(1'b1, so);
        send_bit(1'b1, so);
        send_frame(1, 8'hE4, old);
        chk("R5 aligned read ch1", {24'd0, old}, {24'd0, nvm[1]});
        chk("R5 aligned write", dac_code, exp_code());

        // R3 readback of a temporary value
        send_bit(1'b0, so);
        send_bit(1'b0, so);
        send_frame(2, 8'hA5, old);
        chk("R3 temp readback", {24'd0, old}, 32'h3C);
        chk("R3 do quiet after frame", {31'd0, ser_do}, 32'd0);

        // R8 short select glitch
        @(negedge clk);
        ser_cs = 1'b0;
        @(negedge clk);
        ser_cs = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 glitch keeps code", dac_code, exp_code());
        chk("R8 glitch keeps oe", {31'd0, ser_do_oe}, 32'd1);

        // R7 revert, R6 enable drop
        cs_down();
        chk("R7 revert", dac_code, NV);
        chk("R6 oe low", {31'd0, ser_do_oe}, 32'd0);

        // R9 aborted frame
        cs_up();
        send_bit(1'b1, so);
        send_bit(1'b1, so);
        send_bit(1'b1, so);
        for (int i = 0; i < 3; i++) send_bit(1'b0, so);
        cs_down();
        chk("R9 abort revert", dac_code, NV);
        cs_up();
        send_frame(3, 8'h99, old);
        chk("R9 fresh frame read", {24'd0, old}, {24'd0, nvm[3]});
        chk("R9 fresh frame write", dac_code, exp_code());
        send_bit(1'b0, so);
        send_bit(1'b0, so);

        // random frames
        for (int k = 0; k < 40; k++) begin
            int ch;
            logic [7:0] d;
            logic [7:0] e_old;
            ch = int'($urandom_range(0, 3));
            d = 8'($urandom);
            e_old = cur[ch];
            send_frame(ch, d, old);
            chk("R3 random read", {24'd0, old}, {24'd0, e_old});
            chk("R2 random write", dac_code, exp_code());
            send_bit(1'($urandom), so);
            send_bit(1'($urandom), so);
            if ($urandom_range(0, 5) == 0) begin
                cs_down();
                chk("R7 random revert", dac_code, exp_code());
                cs_up();
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule